// File: doc/BRIEF.md
# Nine-Operation Trace Processor Core

This block is a small 32-bit processor that executes a program held in a word-wide instruction ROM. It fetches one instruction per clock through a combinational ROM read port and decodes a compact custom format. It can add registers, add or load a 12-bit signed constant, load a 20-bit upper constant, copy a register, branch on equality or on unsigned less-than, and jump unconditionally. A trace operation publishes two fixed registers on an output port. Data memory, loads and stores, interrupts and pipelining are absent.

The core is meant as a minimal execution engine for firmware-style test programs, such as an iterative Fibonacci generator whose results come out through the trace port. Execution ends when the core meets an opcode it does not recognise. It then stops fetching and holds a halted indication until the next reset.

Top module: `nano9_core`

## Requirements
- R1: The opcode sits in instruction bits [6:0]. Values 1..9 are legal, with add=1, addi=2, beq=3, bltu=4, call=5, j=6, li=7, lui=8 and mv=9. The value 0 and every value above 9 are illegal. An illegal opcode raises `halted` on the next clock edge, writes no register, and freezes `imem_addr`. `halted` then stays high until reset.
- R2: Register fields are F1 = bits [11:7], F2 = bits [16:12] and F3 = bits [21:17]. Each selects one of 32 registers of 32 bits.
- R3: Register 0 always reads as zero, and writes to it have no effect.
- R4: add writes F2+F3 (modulo 2^32) to F1. mv copies F2 into F1.
- R5: The 12-bit immediate is bits [31:20], sign-extended. li writes it to F1. addi writes F2 plus the immediate to F1.
- R6: lui writes instruction bits [31:12] into F1 bits [31:12] and clears F1 bits [11:0].
- R7: beq branches when F1 equals F2. bltu branches when F1 is below F2, compared as unsigned values. A taken branch goes to its own byte address plus bits [31:20] sign-extended and multiplied by two. A branch that is not taken goes to its own address plus 4.
- R8: j goes to its own byte address plus bits [31:12] sign-extended and multiplied by two.
- R9: A call pulses `trace_valid` high for exactly one cycle, on the edge after the call executes. At the same time `trace_a` carries register 11 and `trace_b` carries register 12. The call does not alter sequential program flow.
- R10: Reset clears the pc, all registers, `halted` and `trace_valid`. The core executes one instruction per clock. `imem_addr` is the byte pc divided by 4, and straight-line instructions advance it by one word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | IMEM_AW | Word index of the instruction being fetched |
| imem_data | input | 32 | Instruction word at `imem_addr`, same cycle |
| halted | output | 1 | High once an illegal opcode has been met |
| trace_valid | output | 1 | One-cycle strobe for each call |
| trace_a | output | 32 | Register 11 captured at the call |
| trace_b | output | 32 | Register 12 captured at the call |

## Verification
The assertions assume that `imem_data` is a defined word for every address the core can present. They also assume the ROM answers combinationally in the same cycle. The bench meets both conditions with a fully initialised array that is read through a continuous assignment and padded with zero words. Those zero words double as the halting opcode. Branch and jump targets in the stimulus programs always land on word boundaries inside that array. The programs are the Fibonacci loop plus short directed sequences that reach registers only through the trace port.

// File: rtl/nano9_pkg.sv
package nano9_pkg;
  localparam int XLEN   = 32;
  localparam int RIDX_W = 5;
  localparam int NREG   = 1 << RIDX_W;
  localparam int OPC_W  = 7;

  typedef enum logic [OPC_W-1:0] {
    OP_ILL  = 7'd0,
    OP_ADD  = 7'd1,
    OP_ADDI = 7'd2,
    OP_BEQ  = 7'd3,
    OP_BLTU = 7'd4,
    OP_CALL = 7'd5,
    OP_JMP  = 7'd6,
    OP_LI   = 7'd7,
    OP_LUI  = 7'd8,
    OP_MV   = 7'd9
  } opc_e;

  typedef struct packed {
    logic              legal;
    opc_e              op;
    logic              we;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] ra;
    logic [RIDX_W-1:0] rb;
    logic [XLEN-1:0]   imm_s;
    logic [XLEN-1:0]   imm_u;
    logic [XLEN-1:0]   boff;
    logic [XLEN-1:0]   joff;
  } dec_t;
endpackage

// File: rtl/nano9_decode.sv
module nano9_decode
  import nano9_pkg::*;
#(
  parameter int TRACE_REG_A = 11,
  parameter int TRACE_REG_B = 12
) (
  input  logic [XLEN-1:0] instr,
  output dec_t            dec
);
  logic [RIDX_W-1:0] f1, f2, f3;

  assign f1 = instr[11:7];
  assign f2 = instr[16:12];
  assign f3 = instr[21:17];

  always_comb begin
    dec       = '0;
    dec.op    = OP_ILL;
    dec.rd    = f1;
    dec.imm_s = {{(XLEN-12){instr[31]}}, instr[31:20]};
    dec.imm_u = {instr[31:12], 12'h000};
    dec.boff  = {{(XLEN-13){instr[31]}}, instr[31:20], 1'b0};
    dec.joff  = {{(XLEN-21){instr[31]}}, instr[31:12], 1'b0};
    dec.ra    = f2;
    dec.rb    = f3;
    case (instr[OPC_W-1:0])
      OP_ADD:  begin dec.legal = 1'b1; dec.op = OP_ADD;  dec.we = 1'b1; end
      OP_ADDI: begin dec.legal = 1'b1; dec.op = OP_ADDI; dec.we = 1'b1; end
      OP_BEQ:  begin dec.legal = 1'b1; dec.op = OP_BEQ;  dec.ra = f1; dec.rb = f2; end
      OP_BLTU: begin dec.legal = 1'b1; dec.op = OP_BLTU; dec.ra = f1; dec.rb = f2; end
      OP_CALL: begin
        dec.legal = 1'b1;
        dec.op    = OP_CALL;
        dec.ra    = RIDX_W'(TRACE_REG_A);
        dec.rb    = RIDX_W'(TRACE_REG_B);
      end
      OP_JMP:  begin dec.legal = 1'b1; dec.op = OP_JMP; end
      OP_LI:   begin dec.legal = 1'b1; dec.op = OP_LI;  dec.we = 1'b1; end
      OP_LUI:  begin dec.legal = 1'b1; dec.op = OP_LUI; dec.we = 1'b1; end
      OP_MV:   begin dec.legal = 1'b1; dec.op = OP_MV;  dec.we = 1'b1; end
      default: begin dec.legal = 1'b0; dec.op = OP_ILL; end
    endcase
  end
endmodule

// File: rtl/nano9_regfile.sv
module nano9_regfile
  import nano9_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [RIDX_W-1:0] waddr,
  input  logic [XLEN-1:0]   wdata,
  input  logic [RIDX_W-1:0] raddr_a,
  input  logic [RIDX_W-1:0] raddr_b,
  output logic [XLEN-1:0]   rdata_a,
  output logic [XLEN-1:0]   rdata_b
);
  logic [XLEN-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we && (waddr != '0)) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

  AST_X0_READS_ZERO_A: assert property (@(posedge clk) disable iff (rst)
    (raddr_a == '0) |-> (rdata_a == '0)); // R3
  AST_X0_READS_ZERO_B: assert property (@(posedge clk) disable iff (rst)
    (raddr_b == '0) |-> (rdata_b == '0)); // R3
endmodule

// File: rtl/nano9_exec.sv
module nano9_exec
  import nano9_pkg::*;
(
  input  dec_t            dec,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] next_pc
);
  logic [XLEN-1:0] seq_pc;
  logic            take;

  assign seq_pc = pc + XLEN'(4);

  always_comb begin
    case (dec.op)
      OP_ADD:  wdata = opa + opb;
      OP_ADDI: wdata = opa + dec.imm_s;
      OP_LI:   wdata = dec.imm_s;
      OP_LUI:  wdata = dec.imm_u;
      default: wdata = opa;
    endcase
  end

  always_comb begin
    take = 1'b0;
    case (dec.op)
      OP_BEQ:  take = (opa == opb);
      OP_BLTU: take = (opa < opb);
      default: take = 1'b0;
    endcase
  end

  always_comb begin
    if (dec.op == OP_JMP) next_pc = pc + dec.joff;
    else if (take)        next_pc = pc + dec.boff;
    else                  next_pc = seq_pc;
  end
endmodule

// File: rtl/nano9_core.sv
module nano9_core
  import nano9_pkg::*;
#(
  parameter int IMEM_AW = 6
) (
  input  logic               clk,
  input  logic               rst,
  output logic [IMEM_AW-1:0] imem_addr,
  input  logic [XLEN-1:0]    imem_data,
  output logic               halted,
  output logic               trace_valid,
  output logic [XLEN-1:0]    trace_a,
  output logic [XLEN-1:0]    trace_b
);
  logic [XLEN-1:0] pc_q;
  logic            halted_q;
  logic            tv_q;
  logic [XLEN-1:0] ta_q, tb_q;
  dec_t            dec;
  logic [XLEN-1:0] opa, opb, wdata, next_pc;
  logic            rf_we;
  logic            flow_op;

  nano9_decode u_dec (
    .instr (imem_data),
    .dec   (dec)
  );

  assign rf_we = !halted_q && dec.legal && dec.we;

  nano9_regfile u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (rf_we),
    .waddr   (dec.rd),
    .wdata   (wdata),
    .raddr_a (dec.ra),
    .raddr_b (dec.rb),
    .rdata_a (opa),
    .rdata_b (opb)
  );

  nano9_exec u_exec (
    .dec     (dec),
    .pc      (pc_q),
    .opa     (opa),
    .opb     (opb),
    .wdata   (wdata),
    .next_pc (next_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      halted_q <= 1'b0;
      tv_q     <= 1'b0;
      ta_q     <= '0;
      tb_q     <= '0;
    end else begin
      tv_q <= 1'b0;
      if (!halted_q) begin
        if (!dec.legal) begin
          halted_q <= 1'b1;
        end else begin
          pc_q <= next_pc;
          if (dec.op == OP_CALL) begin
            tv_q <= 1'b1;
            ta_q <= opa;
            tb_q <= opb;
          end
        end
      end
    end
  end

  assign imem_addr   = pc_q[IMEM_AW+1:2];
  assign halted      = halted_q;
  assign trace_valid = tv_q;
  assign trace_a     = ta_q;
  assign trace_b     = tb_q;

  assign flow_op = (dec.op == OP_BEQ) || (dec.op == OP_BLTU) || (dec.op == OP_JMP);

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted); // R1
  AST_FETCH_FROZEN: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(imem_addr)); // R1
  AST_ILLEGAL_STOPS: assert property (@(posedge clk) disable iff (rst)
    (!halted && !dec.legal) |=> halted); // R1
  AST_TRACE_FROM_CALL: assert property (@(posedge clk) disable iff (rst)
    trace_valid |-> $past(!halted_q && dec.op == OP_CALL)); // R9
  AST_STRAIGHT_LINE: assert property (@(posedge clk) disable iff (rst)
    (!halted && dec.legal && !flow_op) |=> (imem_addr == IMEM_AW'($past(imem_addr) + 1'b1))); // R10
endmodule

// File: tb/tb_nano9_core.sv
module tb_nano9_core;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam logic [6:0] O_ADD = 7'd1, O_ADDI = 7'd2, O_BEQ = 7'd3, O_BLTU = 7'd4,
                         O_CALL = 7'd5, O_J = 7'd6, O_LI = 7'd7, O_LUI = 7'd8, O_MV = 7'd9;
  localparam int S0 = 8, S1 = 9, A0 = 10, A1 = 11, A2 = 12, A3 = 13, S2 = 18, S3 = 19, S4 = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] imem_addr;
  logic [31:0]   imem_data;
  logic          halted, trace_valid;
  logic [31:0]   trace_a, trace_b;
  logic [31:0]   rom [DEPTH];
  logic [31:0]   tr_a [DEPTH];
  logic [31:0]   tr_b [DEPTH];
  int            tr_n = 0;
  int            checks = 0;
  int            failures = 0;

  always #5 clk = ~clk;

  assign imem_data = rom[imem_addr];

  nano9_core #(.IMEM_AW(AW)) dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .halted(halted), .trace_valid(trace_valid), .trace_a(trace_a), .trace_b(trace_b)
  );

  always @(negedge clk) begin
    if (!rst && trace_valid && tr_n < DEPTH) begin
      tr_a[tr_n] = trace_a;
      tr_b[tr_n] = trace_b;
      tr_n = tr_n + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] e_r(logic [6:0] op, int f1, int f2, int f3);
    return {10'd0, 5'(f3), 5'(f2), 5'(f1), op};
  endfunction
  function automatic logic [31:0] e_i(logic [6:0] op, int f1, int f2, int imm);
    logic [31:0] v = imm;
    return {v[11:0], 3'd0, 5'(f2), 5'(f1), op};
  endfunction
  function automatic logic [31:0] e_b(logic [6:0] op, int f1, int f2, int words);
    logic [31:0] v = words * 2;
    return {v[11:0], 3'd0, 5'(f2), 5'(f1), op};
  endfunction
  function automatic logic [31:0] e_j(int words);
    logic [31:0] v = words * 2;
    return {v[19:0], 5'd0, O_J};
  endfunction
  function automatic logic [31:0] e_u(int rd, logic [19:0] u);
    return {u, 5'(rd), O_LUI};
  endfunction

  task automatic clear_rom();
    for (int i = 0; i < DEPTH; i++) rom[i] = 32'h0;
  endtask

  task automatic run_prog(input int limit);
    int cyc;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset imem_addr", 32'(imem_addr), 32'h0);
    chk("R10 reset halted", 32'(halted), 32'h0);
    chk("R10 reset trace_valid", 32'(trace_valid), 32'h0);
    tr_n = 0;
    rst = 1'b0;
    cyc = 0;
    while (!halted && cyc < limit) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= limit) begin
      checks++;
      failures++;
      $display("FAIL watchdog R1 actual=%0d expected<%0d", cyc, limit);
    end
  endtask

  initial begin
    logic [31:0] fa, fb, ft;
    int stop_at;

    // Fibonacci program
    clear_rom();
    rom[0]  = e_i(O_LI, S0, 0, 0);
    rom[1]  = e_i(O_LI, S2, 0, 2);
    rom[2]  = e_u(A0, 20'd1);
    rom[3]  = e_i(O_ADDI, S1, A0, -548);
    rom[4]  = e_i(O_LI, S3, 0, 48);
    rom[5]  = e_i(O_LI, S4, 0, 1);
    rom[6]  = e_j(6);
    rom[7]  = e_r(O_MV, A0, S1, 0);
    rom[8]  = e_r(O_MV, A1, S0, 0);
    rom[9]  = e_r(O_CALL, 0, 0, 0);
    rom[10] = e_i(O_ADDI, S0, S0, 1);
    rom[11] = e_b(O_BEQ, S0, S3, 12);
    rom[12] = e_r(O_MV, A2, S0, 0);
    rom[13] = e_b(O_BLTU, S0, S2, -6);
    rom[14] = e_i(O_LI, A0, 0, 0);
    rom[15] = e_i(O_LI, A2, 0, 1);
    rom[16] = e_r(O_MV, A1, S0, 0);
    rom[17] = e_r(O_MV, A3, A2, 0);
    rom[18] = e_i(O_ADDI, A1, A1, -1);
    rom[19] = e_r(O_ADD, A2, A0, A2);
    rom[20] = e_r(O_MV, A0, A3, 0);
    rom[21] = e_b(O_BLTU, S4, A1, -4);
    rom[22] = e_j(-15);
    rom[23] = e_i(O_LI, A0, 0, 0);
    run_prog(20000);
    chk("R9 fib trace count", 32'(tr_n), 32'd48);
    fa = 0; fb = 1;
    for (int i = 0; i < 48; i++) begin
      if (i < tr_n) begin
        chk($sformatf("R9 trace_a index %0d", i), tr_a[i], 32'(i));
        chk($sformatf("R4 R7 R8 fib value %0d", i), tr_b[i], fa);
      end
      ft = fa + fb; fa = fb; fb = ft;
    end
    chk("R1 halt on zero word addr", 32'(imem_addr), 32'd24);
    chk("R1 halted", 32'(halted), 32'h1);

    // Directed program
    clear_rom();
    rom[0]  = e_i(O_LI, 0, 0, 5);
    rom[1]  = e_r(O_MV, A1, 0, 0);
    rom[2]  = e_u(A2, 20'hABCDE);
    rom[3]  = e_r(O_CALL, 0, 0, 0);
    rom[4]  = e_i(O_LI, A1, 0, -1);
    rom[5]  = e_i(O_LI, A2, 0, 1);
    rom[6]  = e_b(O_BLTU, A2, A1, 2);
    rom[7]  = e_i(O_LI, A2, 0, 99);
    rom[8]  = e_r(O_CALL, 0, 0, 0);
    rom[9]  = e_b(O_BLTU, A1, A2, 2);
    rom[10] = e_i(O_ADDI, A2, A2, -3);
    rom[11] = e_r(O_CALL, 0, 0, 0);
    rom[12] = e_b(O_BEQ, A1, A2, 2);
    rom[13] = e_r(O_ADD, A1, A1, A2);
    rom[14] = e_r(O_MV, A2, A1, 0);
    rom[15] = e_b(O_BEQ, A1, A2, 2);
    rom[16] = e_i(O_LI, A1, 0, 7);
    rom[17] = e_r(O_CALL, 0, 0, 0);
    rom[18] = 32'h0000_000A;
    rom[19] = e_r(O_CALL, 0, 0, 0);
    run_prog(1000);
    chk("R9 directed trace count", 32'(tr_n), 32'd4);
    chk("R3 x0 write ignored", tr_a[0], 32'h0);
    chk("R6 lui upper only", tr_b[0], 32'hABCDE000);
    chk("R5 li sign extend", tr_a[1], 32'hFFFFFFFF);
    chk("R7 bltu unsigned taken", tr_b[1], 32'h1);
    chk("R5 addi negative, R7 bltu not taken", tr_b[2], 32'hFFFFFFFE);
    chk("R4 add wrap, R7 beq not taken", tr_b[3], 32'hFFFFFFFD);
    chk("R7 beq taken skips", tr_a[3], 32'hFFFFFFFD);
    chk("R1 halt at opcode 10", 32'(imem_addr), 32'd18);
    stop_at = tr_n;
    repeat (6) @(negedge clk);
    chk("R1 halted sticky", 32'(halted), 32'h1);
    chk("R1 fetch frozen", 32'(imem_addr), 32'd18);
    chk("R1 no execution after halt", 32'(tr_n), 32'(stop_at));

    // Register clear at reset, then opcode 127 halts
    clear_rom();
    rom[0] = e_r(O_CALL, 0, 0, 0);
    rom[1] = 32'hFFFF_FFFF;
    rom[2] = e_r(O_CALL, 0, 0, 0);
    run_prog(100);
    chk("R10 regs cleared a", tr_a[0], 32'h0);
    chk("R10 regs cleared b", tr_b[0], 32'h0);
    chk("R1 opcode 127 halts", 32'(imem_addr), 32'd1);
    chk("R1 one trace only", 32'(tr_n), 32'd1);

    // Trace pulse width and field positions via register 31/30 unused paths
    clear_rom();
    rom[0] = e_i(O_LI, 31, 0, 300);
    rom[1] = e_r(O_ADD, A1, 31, 31);
    rom[2] = e_r(O_MV, A2, 31, 0);
    rom[3] = e_r(O_CALL, 0, 0, 0);
    rom[4] = e_r(O_MV, A1, 0, 0);
    rom[5] = e_r(O_MV, A1, 0, 0);
    run_prog(100);
    chk("R2 high register fields", tr_a[0], 32'd600);
    chk("R2 mv from reg 31", tr_b[0], 32'd300);
    chk("R9 single-cycle strobe", 32'(tr_n), 32'd1);
    chk("R10 sequential fetch to end", 32'(imem_addr), 32'd6);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #5_000_000;
    failures++;
    checks++;
    $display("FAIL watchdog global actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule